// File: doc/BRIEF.md
# One-Wire Bus Master Core

This core drives a single open-drain one-wire bus from a small byte-wide register file. Software writes a byte into the data register; the core sends it least significant bit first as eight timed slots, and in every slot it samples the bus, so writing all ones turns the same transfer into a byte read. A command bit runs a bus reset that also checks whether any device answered. Slot and reset timing are counted on a 1 MHz tick supplied from outside the core.

Completion is reported through sticky status flags. Any subset of them can be routed onto one interrupt output whose active level is programmable. The register port has no back-pressure. An access is one cycle long with a write or read strobe, is accepted in that cycle, and read data is valid in the same cycle. Reads of the status and data registers have side effects that take effect at the end of the read cycle. A write to the data register while a byte is already waiting is dropped rather than stalled.

Top module: `owm_master`

## Requirements
- R1: After reset the status register (offset 2) reads 0x0E (bit1 no-device result, bit2 transmit buffer empty and bit3 transmit shifter empty set), the enable register (offset 3) reads 0, the bus is released, and the interrupt output is high (inactive for active-low).
- R2: A write to the data register (offset 1) sends its eight bits LSB first in 70-tick slots; a 1 bit drives the bus low for 6 ticks and a 0 bit for 60 ticks.
- R3: In every slot the bus is sampled at tick 15; after the eighth slot the sampled byte (first bit in bit0) is readable at offset 1 and status bit4 (receive full) is set.
- R4: Writing command bit0 (offset 0) drives the bus low for 480 ticks, samples it 70 ticks after release and sets status bit0 at tick 960; status bit1 becomes 1 when no device pulled the bus low and 0 when one did. Command bit0 reads 1 while the reset is pending or running.
- R5: The interrupt output is the OR of status bits 0, 2, 3, 4, 5 each gated by the enable bit of the same position; enable bit1 = 1 makes it active high, 0 active low.
- R6: A status read returns the flags and then clears bits 0, 2 and 3; bit1 keeps its value; an interrupt raised only by those bits goes inactive.
- R7: A data read clears status bit4. If a second byte finishes while bit4 is set, it is held and status bit5 is set; the next data read returns the first byte and moves the held one in (bit4 stays 1, bit5 clears). No new byte starts while bit5 is set.
- R8: A data write while a byte is still waiting to start is ignored; the waiting byte is sent unchanged.
- R9: Command bit2 drives the bus low only while enable bit6 is set; command bit3 reads the synchronized bus level and bit2 reads 0.
- R10: Writing command bit5 aborts any reset or transfer, releases the bus, drops a waiting byte and returns status to 0x0E, while the enable register keeps its value.
- R11: A data write clears status bit2; when the byte enters the shifter bit2 sets and bit3 clears; bit3 sets again after the eighth slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-cycle pulse at 1 MHz, the timing base |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects at end of cycle) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| ow_in | input | 1 | Level seen on the one-wire line |
| ow_drive_low | output | 1 | 1 turns on the open-drain pull-down |
| irq | output | 1 | Interrupt, level set by enable bit1 |

## Verification
The bench measures every low pulse the core drives, so a swapped bit order or wrong slot width shows as a wrong captured byte or an out-of-range pulse length, and a reset that samples presence at the wrong time reports the opposite presence result. It lets two bytes finish unread, and a core that overwrote the receive buffer, or started a third byte over the held one, returns the wrong data or shows bus activity during the stall. It writes the data register while a byte waits, catching a core that replaced the waiting byte. It flips the interrupt level and reads status while a receive flag is pending, which exposes a core that cleared the wrong flags on a status read, and it aborts a running reset to show that a soft reset that left the bus driven or a done flag armed is caught.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RST  = 2'd1,
    ENG_SLOT = 2'd2
  } eng_state_t;

  localparam logic [2:0] A_CMD  = 3'd0;
  localparam logic [2:0] A_DATA = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_IEN  = 3'd3;
  localparam logic [2:0] A_DIV  = 3'd4;

  // status bit positions
  localparam int S_PD   = 0;
  localparam int S_PDR  = 1;
  localparam int S_TBE  = 2;
  localparam int S_TSRE = 3;
  localparam int S_RBF  = 4;
  localparam int S_RSRF = 5;
  localparam int NSTAT  = 6;
endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/owm_engine.sv
module owm_engine
  import owm_pkg::*;
#(
  parameter int DW       = 8,
  parameter int RST_LOW  = 480,
  parameter int RST_SAMP = 550,
  parameter int RST_END  = 960,
  parameter int SLOT_END = 70,
  parameter int LOW_ONE  = 6,
  parameter int LOW_ZERO = 60,
  parameter int SAMP_AT  = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          tick,
  input  logic          bus_lvl,
  input  logic          go_rst,
  input  logic          go_byte,
  input  logic [DW-1:0] tx_byte,
  output logic          idle,
  output logic          rst_active,
  output logic          drv_low,
  output logic          rst_done,
  output logic          pres_lvl,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte
);
  localparam int CW = $clog2(RST_END);
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] K_RLOW  = CW'(RST_LOW);
  localparam logic [CW-1:0] K_RSAMP = CW'(RST_SAMP);
  localparam logic [CW-1:0] K_RLAST = CW'(RST_END - 1);
  localparam logic [CW-1:0] K_SLAST = CW'(SLOT_END - 1);
  localparam logic [CW-1:0] K_ONE   = CW'(LOW_ONE);
  localparam logic [CW-1:0] K_ZERO  = CW'(LOW_ZERO);
  localparam logic [CW-1:0] K_SAMP  = CW'(SAMP_AT);
  localparam logic [IW-1:0] K_BLAST = IW'(DW - 1);

  eng_state_t    st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ENG_IDLE; cnt <= '0; idx <= '0; sh <= '0;
      rx_byte <= '0; pres_lvl <= 1'b1; rst_done <= 1'b0; byte_done <= 1'b0;
    end else if (soft_rst) begin
      st <= ENG_IDLE; cnt <= '0; idx <= '0;
      rst_done <= 1'b0; byte_done <= 1'b0;
    end else begin
      rst_done  <= 1'b0;
      byte_done <= 1'b0;
      case (st)
        ENG_IDLE: begin
          cnt <= '0;
          idx <= '0;
          if (go_rst) begin
            st <= ENG_RST;
          end else if (go_byte) begin
            st <= ENG_SLOT;
            sh <= tx_byte;
          end
        end
        ENG_RST: if (tick) begin
          if (cnt == K_RSAMP) pres_lvl <= bus_lvl;
          if (cnt == K_RLAST) begin
            st       <= ENG_IDLE;
            rst_done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ENG_SLOT: if (tick) begin
          if (cnt == K_SAMP) rx_byte <= {bus_lvl, rx_byte[DW-1:1]};
          if (cnt == K_SLAST) begin
            cnt <= '0;
            if (idx == K_BLAST) begin
              st        <= ENG_IDLE;
              byte_done <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
              sh  <= {1'b0, sh[DW-1:1]};
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      ENG_RST:  drv_low = (cnt < K_RLOW);
      ENG_SLOT: drv_low = (cnt < (sh[0] ? K_ONE : K_ZERO));
      default:  drv_low = 1'b0;
    endcase
  end

  assign idle       = (st == ENG_IDLE);
  assign rst_active = (st == ENG_RST);
endmodule

// File: rtl/owm_regs.sv
module owm_regs
  import owm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          bus_lvl,
  input  logic          eng_idle,
  input  logic          eng_rst_active,
  input  logic          rst_done,
  input  logic          pres_lvl,
  input  logic          byte_done,
  input  logic [DW-1:0] rx_byte,
  output logic          go_rst,
  output logic          go_byte,
  output logic [DW-1:0] tx_byte,
  output logic          soft_rst,
  output logic          force_low,
  output logic          irq,
  output logic [NSTAT-1:0] status_q
);
  logic          rst_req, tx_full, force_q;
  logic          pd, pdr, tbe, tsre, rbf, rsrf;
  logic [6:0]    ien;
  logic [DW-1:0] div_q, rx_buf;
  logic          wr_cmd, wr_data, wr_ien, wr_div, rd_stat, rd_data;
  logic [NSTAT-1:0] irq_mask;

  assign wr_cmd  = bus_wr && (bus_addr == A_CMD);
  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign wr_ien  = bus_wr && (bus_addr == A_IEN);
  assign wr_div  = bus_wr && (bus_addr == A_DIV);
  assign rd_stat = bus_rd && (bus_addr == A_STAT);
  assign rd_data = bus_rd && (bus_addr == A_DATA);

  assign soft_rst = wr_cmd && bus_wdata[5];
  assign go_rst   = eng_idle && rst_req;
  assign go_byte  = eng_idle && !rst_req && tx_full && !rsrf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0; tx_full <= 1'b0; force_q <= 1'b0; tx_byte <= '0;
      pd <= 1'b0; pdr <= 1'b1; tbe <= 1'b1; tsre <= 1'b1; rbf <= 1'b0; rsrf <= 1'b0;
      ien <= '0; div_q <= '0; rx_buf <= '0;
    end else if (soft_rst) begin
      rst_req <= 1'b0; tx_full <= 1'b0; force_q <= 1'b0;
      pd <= 1'b0; pdr <= 1'b1; tbe <= 1'b1; tsre <= 1'b1; rbf <= 1'b0; rsrf <= 1'b0;
    end else begin
      if (wr_cmd) begin
        force_q <= bus_wdata[2];
        if (bus_wdata[0]) rst_req <= 1'b1;
      end
      if (go_rst) rst_req <= 1'b0;
      if (wr_ien) ien <= bus_wdata[6:0];
      if (wr_div) div_q <= bus_wdata;
      // status read clears the event flags; later set events win
      if (rd_stat) begin
        pd <= 1'b0; tbe <= 1'b0; tsre <= 1'b0;
      end
      if (wr_data && !tx_full) begin
        tx_byte <= bus_wdata;
        tx_full <= 1'b1;
        tbe     <= 1'b0;
      end
      if (go_byte) begin
        tx_full <= 1'b0;
        tbe     <= 1'b1;
        tsre    <= 1'b0;
      end
      if (byte_done) tsre <= 1'b1;
      if (rst_done) begin
        pd  <= 1'b1;
        pdr <= pres_lvl;
      end
      if (rd_data) begin
        if (rsrf) begin
          rx_buf <= rx_byte;
          rsrf   <= 1'b0;
        end else begin
          rbf <= 1'b0;
        end
      end
      if (byte_done) begin
        if (rbf && !rd_data) begin
          rsrf <= 1'b1;
        end else begin
          rx_buf <= rx_byte;
          rbf    <= 1'b1;
        end
      end
    end
  end

  assign status_q  = {rsrf, rbf, tsre, tbe, pdr, pd};
  assign irq_mask  = {ien[5], ien[4], ien[3], ien[2], 1'b0, ien[0]};
  assign irq       = ien[1] ? (|(status_q & irq_mask)) : ~(|(status_q & irq_mask));
  assign force_low = force_q && ien[6];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CMD: begin
        bus_rdata[0] = rst_req | eng_rst_active;
        bus_rdata[3] = bus_lvl;
      end
      A_DATA: bus_rdata = rx_buf;
      A_STAT: bus_rdata[NSTAT-1:0] = status_q;
      A_IEN:  bus_rdata[6:0] = ien;
      A_DIV:  bus_rdata = div_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/owm_master.sv
module owm_master
  import owm_pkg::*;
#(
  parameter int DW       = 8,
  parameter int SYNC     = 2,
  parameter int RST_LOW  = 480,
  parameter int RST_SAMP = 550,
  parameter int RST_END  = 960,
  parameter int SLOT_END = 70,
  parameter int LOW_ONE  = 6,
  parameter int LOW_ZERO = 60,
  parameter int SAMP_AT  = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1us,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ow_in,
  output logic          ow_drive_low,
  output logic          irq
);
  logic          bus_lvl, eng_idle, eng_rst_active, eng_drv_low;
  logic          rst_done, pres_lvl, byte_done, go_rst, go_byte, soft_rst, force_low;
  logic [DW-1:0] rx_byte, tx_byte;
  logic [NSTAT-1:0] status_q;

  owm_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ow_in), .q(bus_lvl)
  );

  owm_engine #(
    .DW(DW), .RST_LOW(RST_LOW), .RST_SAMP(RST_SAMP), .RST_END(RST_END),
    .SLOT_END(SLOT_END), .LOW_ONE(LOW_ONE), .LOW_ZERO(LOW_ZERO), .SAMP_AT(SAMP_AT)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tick(tick_1us), .bus_lvl(bus_lvl),
    .go_rst(go_rst), .go_byte(go_byte), .tx_byte(tx_byte),
    .idle(eng_idle), .rst_active(eng_rst_active), .drv_low(eng_drv_low),
    .rst_done(rst_done), .pres_lvl(pres_lvl), .byte_done(byte_done), .rx_byte(rx_byte)
  );

  owm_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_lvl(bus_lvl),
    .eng_idle(eng_idle), .eng_rst_active(eng_rst_active), .rst_done(rst_done),
    .pres_lvl(pres_lvl), .byte_done(byte_done), .rx_byte(rx_byte),
    .go_rst(go_rst), .go_byte(go_byte), .tx_byte(tx_byte), .soft_rst(soft_rst),
    .force_low(force_low), .irq(irq), .status_q(status_q)
  );

  assign ow_drive_low = eng_drv_low | force_low;
endmodule

// File: rtl/owm_master_chk.sv
module owm_master_chk
  import owm_pkg::*;
#(
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic [2:0]       bus_addr,
  input logic             ow_drive_low,
  input logic             force_low,
  input logic             eng_idle,
  input logic             eng_rst_active,
  input logic             rst_done,
  input logic             byte_done,
  input logic             go_byte,
  input logic [NSTAT-1:0] st,
  input logic [DW-1:0]    rx_byte
);
  // R6: a status read leaves the event flags clear unless a set event coincided
  a_r6_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_STAT && !rst_done && !byte_done && !go_byte)
      |=> (!st[S_PD] && !st[S_TBE] && !st[S_TSRE]));

  // R7: the held byte flag only exists on top of a full receive buffer
  a_r7_held_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    st[S_RSRF] |-> st[S_RBF]);

  // R7: while a byte is held, the receive shifter does not move
  a_r7_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st[S_RSRF] && $past(st[S_RSRF])) |-> $stable(rx_byte));

  // R4: the done flag rises only after a reset cycle ran
  a_r4_done_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |-> $past(eng_rst_active));

  // R4: status bit0 rises only from a reset completion
  a_r4_pd_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[S_PD]) |-> $past(rst_done));

  // R9: with the engine idle, the bus is low only through the enabled force path
  a_r9_idle_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (ow_drive_low && eng_idle) |-> force_low);
endmodule

bind owm_master owm_master_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .ow_drive_low(ow_drive_low), .force_low(force_low), .eng_idle(eng_idle),
  .eng_rst_active(eng_rst_active), .rst_done(rst_done), .byte_done(byte_done),
  .go_byte(go_byte), .st(status_q), .rx_byte(rx_byte)
);

// File: tb/sim_owm_master.sv
module sim_owm_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1us = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ow_in, ow_drive_low, irq;

  int total = 0;
  int bad = 0;

  // device model state
  logic       dev_present = 1'b0;
  logic [7:0] dev_resp = 8'hFF;
  logic [2:0] dev_idx = '0;
  logic       dev_pull = 1'b0;
  logic       prev_low = 1'b0;
  logic       low_seen = 1'b0;
  int         pull_cnt = 0, pres_dly = 0, low_cyc = 0, last_low = 0;
  logic [7:0] cap_byte = '0;
  int         cap_idx = 0;
  int         lens [8];

  always #10 clk = ~clk;

  owm_master u0 (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ow_in(ow_in), .ow_drive_low(ow_drive_low), .irq(irq)
  );

  assign ow_in = ~(ow_drive_low | dev_pull);

  always @(negedge clk) tick_1us = ~tick_1us;

  always @(negedge clk) begin
    if (ow_drive_low) begin
      low_cyc  = low_cyc + 1;
      low_seen = 1'b1;
    end
    if (ow_drive_low && !prev_low) begin
      if (!dev_resp[dev_idx]) pull_cnt = 60;
      dev_idx = dev_idx + 3'd1;
    end
    if (!ow_drive_low && prev_low) begin
      last_low = low_cyc;
      if (low_cyc >= 800) begin
        if (dev_present) pres_dly = 40;
      end else begin
        cap_byte = {(low_cyc < 60), cap_byte[7:1]};
        lens[cap_idx % 8] = low_cyc;
        cap_idx = cap_idx + 1;
      end
      low_cyc = 0;
    end
    if (pres_dly > 0) begin
      pres_dly = pres_dly - 1;
      if (pres_dly == 0) pull_cnt = 200;
    end
    dev_pull = (pull_cnt > 0);
    if (pull_cnt > 0) pull_cnt = pull_cnt - 1;
    prev_low = ow_drive_low;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    total = total + 1;
    if (act < lo || act > hi) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #2 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] tx, input logic [7:0] resp);
    dev_resp = resp; dev_idx = '0; cap_idx = 0;
    wr(3'd1, tx);
    wait_cyc(1180);
  endtask

  // {transmitted byte, device answer}; received byte expected = tx & answer
  localparam logic [15:0] VEC [6] = '{
    16'hA5FF, 16'hFF3C, 16'hFFFF, 16'h00FF, 16'h817E, 16'hFF01
  };

  initial begin
    repeat (150000) @(posedge clk);
    bad = bad + 1; total = total + 1;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);

    // R1 reset state
    rd(3'd2, v); chk("R1 status", v, 8'h0E);
    rd(3'd3, v); chk("R1 enable", v, 8'h00);
    chk("R1 irq", irq, 1);
    chk("R1 bus released", ow_drive_low, 0);
    rd(3'd0, v); chk("R1 cmd/R9 bus level", v, 8'h08);

    // R4 reset without a device
    dev_present = 1'b0;
    wr(3'd0, 8'h01);
    wait_cyc(200);
    chk("R4 driving low", ow_drive_low, 1);
    rd(3'd0, v); chk("R4 cmd busy bit", v[0], 1);
    wait_cyc(1900);
    chk_rng("R4 reset low length", last_low, 959, 960);
    rd(3'd2, v); chk("R4 no device", v, 8'h03);
    rd(3'd2, v); chk("R6 clears done keeps result", v, 8'h02);

    // R4 reset with a device
    dev_present = 1'b1;
    wr(3'd0, 8'h01);
    wait_cyc(2100);
    rd(3'd2, v); chk("R4 device present", v, 8'h01);

    // R2/R3 table
    for (int i = 0; i < 6; i++) begin
      send(VEC[i][15:8], VEC[i][7:0]);
      chk($sformatf("R2 sent byte %0d", i), cap_byte, VEC[i][15:8]);
      rd(3'd2, v); chk($sformatf("R3 rbf/R11 status %0d", i), v, 8'h1C);
      rd(3'd1, v); chk($sformatf("R3 received %0d", i), v, VEC[i][15:8] & VEC[i][7:0]);
      rd(3'd2, v); chk($sformatf("R7 rbf cleared %0d", i), v, 8'h00);
      if (i == 0) begin
        chk_rng("R2 one-bit low", lens[0], 11, 12);
        chk_rng("R2 zero-bit low", lens[1], 119, 120);
      end
    end

    // R11 mid-byte flags
    dev_resp = 8'hFF; dev_idx = '0;
    wr(3'd1, 8'hFF);
    wait_cyc(300);
    rd(3'd2, v); chk("R11 shifting", v, 8'h04);
    wait_cyc(900);
    rd(3'd2, v); chk("R11 done", v, 8'h18);
    rd(3'd1, v); chk("R3 read byte", v, 8'hFF);

    // R5 interrupt, active high on receive full
    wr(3'd3, 8'h12);
    wait_cyc(1);
    chk("R5 idle high-pol", irq, 0);
    send(8'hFF, 8'hFF);
    chk("R5 asserted high", irq, 1);
    rd(3'd1, v);
    chk("R5 cleared by data read", irq, 0);
    wr(3'd3, 8'h10);
    wait_cyc(1);
    chk("R5 idle low-pol", irq, 1);
    send(8'hFF, 8'hFF);
    chk("R5 asserted low", irq, 0);
    rd(3'd2, v);
    chk("R6 status read keeps rbf irq", irq, 0);
    rd(3'd1, v);
    chk("R5 released low-pol", irq, 1);
    wr(3'd3, 8'h03);
    wr(3'd0, 8'h01);
    wait_cyc(2100);
    chk("R5 done irq", irq, 1);
    rd(3'd2, v);
    chk("R6 status read drops irq", irq, 0);
    wr(3'd3, 8'h00);

    // R7/R8 overflow, stall and dropped write
    send(8'h3C, 8'hFF);
    send(8'hC3, 8'hFF);
    rd(3'd2, v); chk("R7 held flag", v, 8'h3C);
    wr(3'd1, 8'h55);
    low_seen = 1'b0;
    wait_cyc(400);
    chk("R7 no start while held", low_seen, 0);
    wr(3'd1, 8'h99);
    rd(3'd2, v); chk("R8 buffer occupied", v, 8'h30);
    dev_resp = 8'hFF; dev_idx = '0; cap_idx = 0;
    rd(3'd1, v); chk("R7 first byte", v, 8'h3C);
    rd(3'd2, v); chk("R7 moved in", v, 8'h14);
    rd(3'd1, v); chk("R7 second byte", v, 8'hC3);
    wait_cyc(1200);
    chk("R8 waiting byte sent", cap_byte, 8'h55);
    rd(3'd1, v); chk("R8 received", v, 8'h55);

    // R9 force low
    wr(3'd3, 8'h40);
    wr(3'd0, 8'h04);
    chk("R9 forced", ow_drive_low, 1);
    wait_cyc(4);
    rd(3'd0, v); chk("R9 level low", v, 8'h00);
    wr(3'd0, 8'h00);
    chk("R9 released", ow_drive_low, 0);
    wait_cyc(4);
    rd(3'd0, v); chk("R9 level high", v, 8'h08);
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h04);
    chk("R9 gated off", ow_drive_low, 0);
    wr(3'd0, 8'h00);

    // R10 soft reset during a bus reset
    wr(3'd3, 8'h12);
    wr(3'd0, 8'h01);
    wait_cyc(100);
    wr(3'd0, 8'h20);
    chk("R10 bus released", ow_drive_low, 0);
    rd(3'd2, v); chk("R10 status", v, 8'h0E);
    rd(3'd0, v); chk("R10 cmd idle", v[0], 0);
    wait_cyc(2000);
    rd(3'd2, v); chk("R10 no late done", v[0], 0);
    rd(3'd3, v); chk("R10 enable kept", v, 8'h12);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule